// File: doc/BRIEF.md
# Battery-Backed Clock Power and Wake Controller

This block is the power-control corner of a battery-backed real-time clock. A host reaches one 8-bit control register through a synchronous register port. The block turns that register, a supply-present flag and three event sources into two outputs. The first is an active-low interrupt. The second is an active-low power-enable that can be released to high impedance, modelled here as a value plus an output enable.

While the system supply is up, enabled events pull both outputs low. While it is down, only the power-enable can act: it wakes the system. Once the supply returns, the interrupt joins it.

A separate sequencer runs a bulk clear of the 114-byte user RAM through a write port. It starts when the clear input falls and the clear enable is set. When it finishes it raises its own completion flag, which can drive the interrupt.

The power router has three states:
- `PM_MAIN`: supply present.
- `PM_BATT`: supply absent, nothing pending.
- `PM_BATT_WAKE`: supply absent, an enabled event pending.

Its transitions are:
- `PM_MAIN`→`PM_BATT` or `PM_BATT_WAKE` on supply loss, chosen by whether an enabled event is pending.
- `PM_BATT`→`PM_BATT_WAKE` when an enabled event arrives.
- `PM_BATT_WAKE`→`PM_BATT` when the flags are cleared.
- Either battery state→`PM_MAIN` when the supply returns.

The clear sequencer also has three states:
- `CS_IDLE`, which goes to `CS_RUN` on an accepted request.
- `CS_RUN`, which writes one word per clock and goes to `CS_FIN` after the last address.
- `CS_FIN`, which lasts one cycle and signals completion, then returns to `CS_IDLE`.

Top module: `rtc_pwr_ctl`

## Requirements
- R1: The control register answers at address 0x4B: a write there is read back unchanged on `reg_rdata`, and any other address reads 0x00. The bit meanings are: bit0 kickstart interrupt enable, bit1 wake interrupt enable, bit2 clear-done interrupt enable, bit3 keep power output driven on supply loss, bit4 RAM clear enable, bit5 crystal select (stored only), bit6 32 kHz output enable, bit7 auxiliary battery enable (stored only). Reset value is 0x00.
- R2: On every rise of `sys_pwr_ok` bit6 is forced to 1 at the next clock, overriding a write. The first cycle after reset with the supply present counts as a rise, so the register then reads 0x40.
- R3: With the supply present and an enabled event flag set, `irq_n` and `pwr_n` are both 0 and `pwr_oe` is 1.
- R4: While an event's enable bit is 0, its flag has no effect on `irq_n`, `pwr_n` or `pwr_oe`. The flag is still recorded, and setting the enable later asserts the outputs.
- R5: With the supply absent, an enabled wake or kickstart flag drives `pwr_n` to 0 with `pwr_oe` at 1, while `irq_n` stays 1. When the supply returns, `irq_n` also goes to 0.
- R6: A falling edge on `kick_n`, after a two-flop synchronizer, sets the kickstart flag. A one-cycle high on `wake_match` sets the wake flag.
- R7: With the supply absent and no enabled event pending, `pwr_n` is 1 and `pwr_oe` equals bit3. With the supply present, `pwr_oe` is 1.
- R8: Flags stay set until a `flag_clr` strobe clears them. `flag_clr_sel` bit0 clears kickstart, bit1 clears wake and bit2 clears clear-done. The outputs release after the strobe.
- R9: With bit4 set, a synchronized falling edge on `rclr_n` produces exactly 114 consecutive `ram_we` cycles. They carry addresses 0 to 113 in order and data 0.
- R10: With bit4 clear, a falling edge on `rclr_n` produces no `ram_we`.
- R11: A falling edge on `rclr_n` during a clear neither restarts nor extends it.
- R12: When the clear completes, the clear-done flag is set. With bit2 set and the supply present this drives `irq_n` to 0; with bit2 clear `irq_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| flag_clr | input | 1 | Flag clear strobe |
| flag_clr_sel | input | 3 | Which flags the strobe clears |
| sys_pwr_ok | input | 1 | System supply present |
| wake_match | input | 1 | Wake alarm match pulse |
| kick_n | input | 1 | Kickstart input, active low, asynchronous |
| rclr_n | input | 1 | RAM clear request, active low, asynchronous |
| irq_n | output | 1 | Interrupt, active low |
| pwr_n | output | 1 | Power enable value, active low |
| pwr_oe | output | 1 | Power enable drive; 0 means high impedance |
| ram_we | output | 1 | User RAM write enable |
| ram_addr | output | 7 | User RAM write address |
| ram_wdata | output | 8 | User RAM write data |

## Verification
The hardest situation to reach is an enabled event arriving while the supply is off, followed by the supply's return. The stimulus has to drop `sys_pwr_ok`, let the router settle in a battery state, fire the event, and only then restore the supply. Directed sequences walk this path for both event kinds. Seeded random trials then mix supply level, enable bits, power-on-fail select and event combinations against a bench model of the routing. A second hard case is a clear request that arrives while a clear is already running; it is produced by pulsing `rclr_n` again partway through the 114 writes.

// File: rtl/rtc_pwr_pkg.sv
package rtc_pwr_pkg;

    // Control register bit positions
    localparam int B_KSE  = 0;
    localparam int B_WIE  = 1;
    localparam int B_RIE  = 2;
    localparam int B_PRS  = 3;
    localparam int B_RCE  = 4;
    localparam int B_XSEL = 5;
    localparam int B_E32  = 6;
    localparam int B_AUX  = 7;

    // Flag-clear select positions
    localparam int F_KICK = 0;
    localparam int F_WAKE = 1;
    localparam int F_RCLR = 2;

    typedef enum logic [1:0] {
        PM_MAIN      = 2'd0,
        PM_BATT      = 2'd1,
        PM_BATT_WAKE = 2'd2
    } pm_state_t;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_RUN  = 2'd1,
        CS_FIN  = 2'd2
    } clr_state_t;

endpackage

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_n,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;
    logic              prev_q;

    // Shift the asynchronous level through the synchronizer chain
    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din_n;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din_n};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sh_q   <= sh_d;
            prev_q <= sh_q[LAST];
        end
    end

    assign fall = prev_q & ~sh_q[LAST];

endmodule

// File: rtl/rtc_clr_seq.sv
module rtc_clr_seq
    import rtc_pwr_pkg::*;
#(
    parameter int WORDS  = 114,
    parameter int AW     = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              done
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(WORDS - 1);

    clr_state_t state_q, state_d;
    logic [AW-1:0] cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic; requests outside CS_IDLE are dropped
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE: if (start) state_d = CS_RUN;
            CS_RUN:  if (cnt_q == LAST_ADDR) state_d = CS_FIN;
            CS_FIN:  state_d = CS_IDLE;
            default: state_d = CS_IDLE;
        endcase
    end

    // Address counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (state_q == CS_RUN) cnt_q <= cnt_q + 1'b1;
        else                       cnt_q <= '0;
    end

    // Outputs
    always_comb begin
        ram_we = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            CS_IDLE: ;
            CS_RUN:  ram_we = 1'b1;
            CS_FIN:  done   = 1'b1;
            default: ;
        endcase
    end

    assign ram_addr  = cnt_q;
    assign ram_wdata = '0;

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_pwr_pkg::*;
#(
    parameter logic [7:0] CTRL_ADDR = 8'h4B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sys_pwr_ok,
    input  logic       wake_evt,
    input  logic       kick_evt,
    input  logic       rclr_evt,
    input  logic       flag_clr,
    input  logic [2:0] flag_clr_sel,
    output logic [7:0] ctrl_q,
    output logic       wake_f,
    output logic       kick_f,
    output logic       rclr_f
);
    logic       sys_q;
    logic       hit;
    logic [7:0] ctrl_d;
    logic [2:0] clr_m;

    assign hit   = (reg_addr == CTRL_ADDR);
    assign clr_m = flag_clr ? flag_clr_sel : 3'b000;

    // A write loads the register; a supply rise then forces the 32 kHz enable on
    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_wr && hit) ctrl_d = reg_wdata;
        if (sys_pwr_ok && !sys_q) ctrl_d[B_E32] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sys_q  <= 1'b0;
            wake_f <= 1'b0;
            kick_f <= 1'b0;
            rclr_f <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            sys_q  <= sys_pwr_ok;
            // A new event beats a clear in the same cycle
            wake_f <= wake_evt | (wake_f & ~clr_m[F_WAKE]);
            kick_f <= kick_evt | (kick_f & ~clr_m[F_KICK]);
            rclr_f <= rclr_evt | (rclr_f & ~clr_m[F_RCLR]);
        end
    end

    assign reg_rdata = hit ? ctrl_q : 8'h00;

endmodule

// File: rtl/rtc_pwr_fsm.sv
module rtc_pwr_fsm
    import rtc_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sys_pwr_ok,
    input  logic wake_f,
    input  logic kick_f,
    input  logic rclr_f,
    input  logic en_wake,
    input  logic en_kick,
    input  logic en_rclr,
    input  logic keep_drive,
    output logic irq_n,
    output logic pwr_n,
    output logic pwr_oe
);
    pm_state_t state_q, state_d;
    logic pend_pwr;
    logic pend_irq;

    assign pend_pwr = (wake_f & en_wake) | (kick_f & en_kick);
    assign pend_irq = pend_pwr | (rclr_f & en_rclr);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PM_MAIN;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_MAIN:
                if (!sys_pwr_ok) state_d = pend_pwr ? PM_BATT_WAKE : PM_BATT;
            PM_BATT:
                if (sys_pwr_ok)    state_d = PM_MAIN;
                else if (pend_pwr) state_d = PM_BATT_WAKE;
            PM_BATT_WAKE:
                if (sys_pwr_ok)     state_d = PM_MAIN;
                else if (!pend_pwr) state_d = PM_BATT;
            default: state_d = PM_MAIN;
        endcase
    end

    // Outputs
    always_comb begin
        irq_n  = 1'b1;
        pwr_n  = 1'b1;
        pwr_oe = 1'b1;
        unique case (state_q)
            PM_MAIN: begin
                irq_n = ~pend_irq;
                pwr_n = ~pend_pwr;
            end
            PM_BATT:
                pwr_oe = keep_drive;
            PM_BATT_WAKE:
                pwr_n = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/rtc_pwr_ctl.sv
module rtc_pwr_ctl
    import rtc_pwr_pkg::*;
#(
    parameter logic [7:0] CTRL_ADDR   = 8'h4B,
    parameter int         RAM_WORDS   = 114,
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2,
    localparam int        AW          = $clog2(RAM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              flag_clr,
    input  logic [2:0]        flag_clr_sel,
    input  logic              sys_pwr_ok,
    input  logic              wake_match,
    input  logic              kick_n,
    input  logic              rclr_n,
    output logic              irq_n,
    output logic              pwr_n,
    output logic              pwr_oe,
    output logic              ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);
    logic [7:0] ctrl_q;
    logic kick_fall, rclr_fall;
    logic wake_f, kick_f, rclr_f;
    logic clr_done;

    rtc_edge_sync #(.STAGES(SYNC_STAGES)) u_kick_sync (
        .clk(clk), .rst_n(rst_n), .din_n(kick_n), .fall(kick_fall)
    );

    rtc_edge_sync #(.STAGES(SYNC_STAGES)) u_rclr_sync (
        .clk(clk), .rst_n(rst_n), .din_n(rclr_n), .fall(rclr_fall)
    );

    rtc_ctrl_regs #(.CTRL_ADDR(CTRL_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sys_pwr_ok(sys_pwr_ok),
        .wake_evt(wake_match), .kick_evt(kick_fall), .rclr_evt(clr_done),
        .flag_clr(flag_clr), .flag_clr_sel(flag_clr_sel),
        .ctrl_q(ctrl_q), .wake_f(wake_f), .kick_f(kick_f), .rclr_f(rclr_f)
    );

    rtc_clr_seq #(.WORDS(RAM_WORDS), .AW(AW), .DATA_W(DATA_W)) u_clr (
        .clk(clk), .rst_n(rst_n),
        .start(rclr_fall & ctrl_q[B_RCE]),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .done(clr_done)
    );

    rtc_pwr_fsm u_pwr (
        .clk(clk), .rst_n(rst_n), .sys_pwr_ok(sys_pwr_ok),
        .wake_f(wake_f), .kick_f(kick_f), .rclr_f(rclr_f),
        .en_wake(ctrl_q[B_WIE]), .en_kick(ctrl_q[B_KSE]),
        .en_rclr(ctrl_q[B_RIE]), .keep_drive(ctrl_q[B_PRS]),
        .irq_n(irq_n), .pwr_n(pwr_n), .pwr_oe(pwr_oe)
    );

endmodule

// File: rtl/rtc_pwr_ctl_chk.sv
module rtc_pwr_ctl_chk #(
    parameter int RAM_WORDS = 114,
    parameter int AW        = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sys_pwr_ok,
    input logic          irq_n,
    input logic          pwr_n,
    input logic          pwr_oe,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr,
    input logic [7:0]    ctrl_q
);
    // R2: a supply rise sets the 32 kHz enable one clock later
    a_r2_e32k_forced: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_pwr_ok) |=> ctrl_q[6]);

    // R5: a settled supply loss keeps the interrupt released
    a_r5_batt_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_pwr_ok && $past(!sys_pwr_ok)) |-> irq_n);

    // R7: a settled supply keeps the power output driven
    a_r7_main_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_pwr_ok && $past(sys_pwr_ok)) |-> pwr_oe);

    // R3: an asserted power output is never released to high impedance
    a_r3_low_is_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |-> pwr_oe);

    // R9: clear addresses advance by one each write cycle
    a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we)) |-> ram_addr == $past(ram_addr) + 1'b1);

    // R9: clear addresses stay inside the user RAM
    a_r9_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (int'(ram_addr) < RAM_WORDS));

    // R11: every clear run starts from address zero
    a_r11_run_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we) |-> ram_addr == '0);

endmodule

bind rtc_pwr_ctl rtc_pwr_ctl_chk #(.RAM_WORDS(RAM_WORDS), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sys_pwr_ok(sys_pwr_ok),
    .irq_n(irq_n), .pwr_n(pwr_n), .pwr_oe(pwr_oe),
    .ram_we(ram_we), .ram_addr(ram_addr), .ctrl_q(ctrl_q)
);

// File: tb/rtc_pwr_ctl_bench.sv
module rtc_pwr_ctl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       flag_clr = 1'b0;
    logic [2:0] flag_clr_sel = 3'b000;
    logic       sys_pwr_ok = 1'b1;
    logic       wake_match = 1'b0;
    logic       kick_n = 1'b1;
    logic       rclr_n = 1'b1;
    logic       irq_n, pwr_n, pwr_oe, ram_we;
    logic [6:0] ram_addr;
    logic [7:0] ram_wdata;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int addr_err = 0;
    int exp_addr = 0;

    always #2 clk = ~clk;

    rtc_pwr_ctl u_rtc_pwr_ctl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flag_clr(flag_clr),
        .flag_clr_sel(flag_clr_sel), .sys_pwr_ok(sys_pwr_ok),
        .wake_match(wake_match), .kick_n(kick_n), .rclr_n(rclr_n),
        .irq_n(irq_n), .pwr_n(pwr_n), .pwr_oe(pwr_oe), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    // RAM write monitor (R9, R11)
    always @(negedge clk) begin
        if (rst_n && ram_we) begin
            wr_cnt = wr_cnt + 1;
            if (int'(ram_addr) != exp_addr || ram_wdata != 8'h00) addr_err = addr_err + 1;
            exp_addr = exp_addr + 1;
        end else begin
            exp_addr = 0;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        @(negedge clk);
        check(req, reg_rdata, exp);
        step(1);
    endtask

    task automatic clr_flags(input logic [2:0] sel);
        flag_clr = 1'b1; flag_clr_sel = sel;
        step(1);
        flag_clr = 1'b0; flag_clr_sel = 3'b000;
    endtask

    task automatic pulse_wake();
        wake_match = 1'b1;
        step(1);
        wake_match = 1'b0;
    endtask

    task automatic pulse_kick();
        kick_n = 1'b0;
        step(4);
        kick_n = 1'b1;
        step(4);
    endtask

    task automatic pulse_rclr();
        rclr_n = 1'b0;
        step(4);
        rclr_n = 1'b1;
    endtask

    // Expected {irq_n, pwr_n, pwr_oe} from supply, control bits and flags
    function automatic logic [2:0] model(input logic sys, input logic [7:0] c,
                                         input logic wf, input logic kf, input logic rf);
        logic pp, pi;
        pp = (wf & c[1]) | (kf & c[0]);
        pi = pp | (rf & c[2]);
        if (sys) return {~pi, ~pp, 1'b1};
        return {1'b1, ~pp, c[3] | pp};
    endfunction

    task automatic out_check(input string req, input logic [2:0] exp);
        @(negedge clk);
        check(req, {5'd0, irq_n, pwr_n, pwr_oe}, {5'd0, exp});
        step(1);
    endtask

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1'b1;

        // Reset state
        @(negedge clk);
        check("R7 reset outputs", {5'd0, irq_n, pwr_n, pwr_oe}, 8'h07);
        check("R9 reset no write", {7'd0, ram_we}, 8'h00);
        step(1);
        rd_check("R2 reset force", 8'h4B, 8'h40);

        // R1 random register access
        for (int i = 0; i < 12; i++) begin
            logic [7:0] v, oa;
            v  = 8'($urandom) & 8'hE8; // enables and clear bit off
            wr_reg(8'h4B, v);
            rd_check("R1 readback", 8'h4B, v);
            oa = 8'($urandom);
            if (oa == 8'h4B) oa = 8'h4C;
            wr_reg(oa, 8'hFF);
            rd_check("R1 other address", oa, 8'h00);
            rd_check("R1 unaffected", 8'h4B, v);
        end

        // R2 force on supply rise
        wr_reg(8'h4B, 8'h00);
        rd_check("R2 cleared", 8'h4B, 8'h00);
        sys_pwr_ok = 1'b0; step(3);
        sys_pwr_ok = 1'b1; step(2);
        rd_check("R2 forced on rise", 8'h4B, 8'h40);

        // R3 wake with supply present
        clr_flags(3'b111);
        wr_reg(8'h4B, 8'h02);
        pulse_wake(); step(1);
        out_check("R3 wake main", 3'b001);
        // R8 clear releases
        clr_flags(3'b010); step(1);
        out_check("R8 wake cleared", 3'b111);

        // R4 disabled flag no effect, retained
        wr_reg(8'h4B, 8'h00);
        pulse_wake(); step(2);
        out_check("R4 disabled wake", 3'b111);
        wr_reg(8'h4B, 8'h02); step(1);
        out_check("R4 enable later", 3'b001);
        clr_flags(3'b111); step(1);

        // R5 wake on battery, then supply returns
        sys_pwr_ok = 1'b0; step(3);
        out_check("R7 battery idle prs0", 3'b110);
        pulse_wake(); step(2);
        out_check("R5 battery wake", 3'b101);
        sys_pwr_ok = 1'b1; step(2);
        out_check("R5 supply back", 3'b001);
        clr_flags(3'b111); step(1);

        // R6 kickstart via synchronizer
        wr_reg(8'h4B, 8'h01);
        pulse_kick(); step(2);
        out_check("R6 kickstart", 3'b001);
        clr_flags(3'b001); step(1);
        out_check("R8 kick cleared", 3'b111);

        // R7 power-on-fail select
        wr_reg(8'h4B, 8'h08);
        sys_pwr_ok = 1'b0; step(3);
        out_check("R7 battery prs1", 3'b111);
        sys_pwr_ok = 1'b1; step(3);

        // R10 clear disabled
        wr_reg(8'h4B, 8'h04);
        wr_cnt = 0;
        pulse_rclr(); step(150);
        check("R10 no writes", 8'(wr_cnt), 8'd0);
        out_check("R10 no irq", 3'b111);

        // R9, R11, R12 clear with retrigger during run
        wr_reg(8'h4B, 8'h14);
        wr_cnt = 0; addr_err = 0;
        pulse_rclr(); step(30);
        pulse_rclr(); step(200);
        check("R9 write count", 8'(wr_cnt), 8'd114);
        check("R9 address order", 8'(addr_err), 8'd0);
        check("R11 single run", 8'(wr_cnt), 8'd114);
        out_check("R12 done irq", 3'b011);
        clr_flags(3'b100); step(1);
        out_check("R8 done cleared", 3'b111);

        // R12 completion with interrupt disabled
        wr_reg(8'h4B, 8'h10);
        wr_cnt = 0;
        pulse_rclr(); step(200);
        check("R9 second run count", 8'(wr_cnt), 8'd114);
        out_check("R12 masked", 3'b111);
        clr_flags(3'b111); step(1);

        // Random routing trials (R3 R5 R7)
        for (int t = 0; t < 40; t++) begin
            logic s, w, k;
            logic [7:0] c;
            clr_flags(3'b111);
            s = 1'($urandom);
            sys_pwr_ok = s;
            step(3);
            c = 8'($urandom) & 8'hEB;
            wr_reg(8'h4B, c);
            w = 1'($urandom);
            k = 1'($urandom);
            if (w) pulse_wake();
            if (k) pulse_kick();
            step(3);
            out_check("R7 random routing", model(s, c, w, k, 1'b0));
        end
        sys_pwr_ok = 1'b1;
        step(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule